// File: doc/BRIEF.md
# Pedestal Subtractor with Zero Clamp and Overflow Saturation

This block handles one converter channel per readout step. It takes an 11-bit raw sample and the pedestal stored for that channel. It removes the pedestal from the sample and registers the corrected value. A sequencer outside the block chooses the channel and fetches the pedestal. The sequencer pulses `load` once for each channel, and the registered word stays on `result` until the next pulse.

Some results would be zero or negative. Those are clamped to zero and marked with `zero_flag`. A two-bit resolution code sets which of the upper raw bits (7 to 10) count as the overflow condition. When the raw sample meets that condition, the output saturates at 2047 and `ovf_flag` is raised. Overflow ranks above the zero clamp. Both flags are registered together with the data word.

Top module: `ped_sub_clamp`

## Requirements
- R1: On a `load` cycle with no overflow and `raw > pedestal`, the next `result` equals `raw - pedestal`, and both flags are low.
- R2: On a `load` cycle with no overflow and `raw == pedestal`, the next `result` is 0 and `zero_flag` is 1.
- R3: On a `load` cycle with no overflow and `raw < pedestal`, the block detects the borrow. The next `result` is 0 and `zero_flag` is 1, with no wrapped value.
- R4: The `res_sel` code selects the overflow condition on raw bits: 0 = 8-bit (bit 8 set), 1 = 9-bit (bit 9 set), 2 = 10-bit (bit 10 set), 3 = 11-bit (bits 7, 8, 9 and 10 all set). Raw bits outside the selected mask play no part in overflow.
- R5: On a `load` cycle with overflow, the next `result` is 2047, `ovf_flag` is 1 and `zero_flag` is 0, whatever the pedestal is.
- R6: While `load` is low, `result`, `zero_flag` and `ovf_flag` keep their values, whatever happens on the other inputs.
- R7: A synchronous active-high `rst` sets `result` to 0 and clears both flags on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Strobe that registers the current channel |
| raw | input | 11 | Raw converter sample |
| pedestal | input | 11 | Pedestal for the same channel |
| res_sel | input | 2 | Resolution code that picks the overflow mask |
| result | output | 11 | Registered corrected value |
| zero_flag | output | 1 | Result was clamped from zero or below |
| ovf_flag | output | 1 | Raw sample overflowed and the output is saturated |

## Verification
The assertions check on every clock edge that each `load` produces the right class of output: saturation, clamp or exact difference. Their overflow mask is decoded independently of the design. They also check that the two flags never assert together and that idle cycles leave the output register unchanged. Some cases only the bench's directed scenarios can demonstrate: the threshold edges on both sides of each resolution, a set upper bit that is outside the selected mask, and overflow winning over a pedestal larger than the sample.

// File: rtl/ped_pkg.sv
package ped_pkg;
    localparam int DATA_W = 11;
    localparam int DIFF_W = DATA_W + 1;
    localparam int OVF_LO = 7;
    localparam int OVF_N  = DATA_W - OVF_LO;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [OVF_N-1:0]  omask_t;

    typedef enum logic [1:0] {
        RES_8B  = 2'd0,
        RES_9B  = 2'd1,
        RES_10B = 2'd2,
        RES_11B = 2'd3
    } res_e;

    typedef struct packed {
        word_t data;
        logic  zero;
        logic  ovf;
    } outw_t;

    // Mask over raw bits OVF_LO.. that must all be set for overflow
    function automatic omask_t ovf_mask(res_e r);
        omask_t m;
        case (r)
            RES_8B:  m = omask_t'(1) << 1;
            RES_9B:  m = omask_t'(1) << 2;
            RES_10B: m = omask_t'(1) << 3;
            default: m = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/ped_subtract.sv
module ped_subtract #(
    parameter int W = 11
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic [W-1:0] diff,
    output logic         nonpos
);
    localparam int WX = W + 1;
    logic [WX-1:0] wide;

    always_comb begin
        wide   = {1'b0, minuend} - {1'b0, subtrahend};
        diff   = wide[W-1:0];
        nonpos = wide[WX-1] | (wide[W-1:0] == '0);
    end
endmodule

// File: rtl/ped_ovf_detect.sv
module ped_ovf_detect
    import ped_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int LO = OVF_LO,
    parameter int N  = OVF_N
) (
    input  logic [W-1:0] raw,
    input  res_e         res,
    output logic         ovf
);
    logic [N-1:0] mask;
    logic [N-1:0] hit;

    assign mask = ovf_mask(res);

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign hit[i] = ~mask[i] | raw[LO+i];
    end

    assign ovf = (|mask) & (&hit);
endmodule

// File: rtl/ped_out_reg.sv
module ped_out_reg
    import ped_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  outw_t nxt,
    output outw_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/ped_sub_clamp.sv
module ped_sub_clamp
    import ped_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] raw,
    input  logic [DATA_W-1:0] pedestal,
    input  logic [1:0]        res_sel,
    output logic [DATA_W-1:0] result,
    output logic              zero_flag,
    output logic              ovf_flag
);
    word_t diff;
    logic  nonpos;
    logic  ovf;
    outw_t nxt;
    outw_t q;

    ped_subtract #(.W(DATA_W)) i_sub (
        .minuend    (raw),
        .subtrahend (pedestal),
        .diff       (diff),
        .nonpos     (nonpos)
    );

    ped_ovf_detect #(.W(DATA_W), .LO(OVF_LO), .N(OVF_N)) i_ovf (
        .raw (raw),
        .res (res_e'(res_sel)),
        .ovf (ovf)
    );

    always_comb begin
        nxt.ovf  = ovf;
        nxt.zero = ~ovf & nonpos;
        if (ovf)         nxt.data = '1;
        else if (nonpos) nxt.data = '0;
        else             nxt.data = diff;
    end

    ped_out_reg i_reg (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .nxt  (nxt),
        .q    (q)
    );

    assign result    = q.data;
    assign zero_flag = q.zero;
    assign ovf_flag  = q.ovf;
endmodule

// File: rtl/ped_sub_clamp_chk.sv
module ped_sub_clamp_chk
    import ped_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic [DATA_W-1:0] raw,
    input logic [DATA_W-1:0] pedestal,
    input logic [1:0]        res_sel,
    input logic [DATA_W-1:0] result,
    input logic              zero_flag,
    input logic              ovf_flag
);
    logic over_c;
    always_comb begin
        case (res_sel)
            2'd0:    over_c = raw[8];
            2'd1:    over_c = raw[9];
            2'd2:    over_c = raw[10];
            default: over_c = raw[10] & raw[9] & raw[8] & raw[7];
        endcase
    end

    assert_diff_R1: assert property (@(posedge clk) disable iff (rst)
        (load && !over_c && raw > pedestal) |=>
            (result == $past(raw - pedestal) && !zero_flag && !ovf_flag));

    assert_clamp_R2_R3: assert property (@(posedge clk) disable iff (rst)
        (load && !over_c && raw <= pedestal) |=>
            (result == '0 && zero_flag && !ovf_flag));

    assert_saturate_R4_R5: assert property (@(posedge clk) disable iff (rst)
        (load && over_c) |=> (result == '1 && ovf_flag && !zero_flag));

    assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(zero_flag && ovf_flag));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(result) && $stable(zero_flag) && $stable(ovf_flag)));

    assert_reset_R7: assert property (@(posedge clk)
        rst |=> (result == '0 && !zero_flag && !ovf_flag));
endmodule

bind ped_sub_clamp ped_sub_clamp_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .raw       (raw),
    .pedestal  (pedestal),
    .res_sel   (res_sel),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag)
);

// File: tb/test_ped_sub_clamp.sv
`timescale 1ns/1ps
module test_ped_sub_clamp;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [10:0] raw = '0;
    logic [10:0] pedestal = '0;
    logic [1:0]  res_sel = '0;
    logic [10:0] result;
    logic        zero_flag;
    logic        ovf_flag;

    int total = 0;
    int bad = 0;
    int exp_data = 0;
    int exp_zero = 0;
    int exp_ovf = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ped_sub_clamp i_ped_sub_clamp (
        .clk(clk), .rst(rst), .load(load), .raw(raw), .pedestal(pedestal),
        .res_sel(res_sel), .result(result), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
    );

    function automatic int over_ref(int r, int s);
        case (s)
            0: return (r / 256) % 2;
            1: return (r / 512) % 2;
            2: return (r / 1024) % 2;
            default: return (r / 128) == 15 ? 1 : 0;
        endcase
    endfunction

    // reference model: one clock edge
    task automatic step(input bit ld, input int r, input int p, input int s, input string tag);
        raw = 11'(r); pedestal = 11'(p); res_sel = 2'(s); load = ld;
        @(posedge clk);
        if (rst) begin
            exp_data = 0; exp_zero = 0; exp_ovf = 0;
        end else if (ld) begin
            if (over_ref(r, s) != 0) begin
                exp_data = 2047; exp_zero = 0; exp_ovf = 1;
            end else if (r - p <= 0) begin
                exp_data = 0; exp_zero = 1; exp_ovf = 0;
            end else begin
                exp_data = r - p; exp_zero = 0; exp_ovf = 0;
            end
        end
        #1;
        total++;
        if (int'(result) != exp_data || int'(zero_flag) != exp_zero || int'(ovf_flag) != exp_ovf) begin
            bad++;
            $display("FAIL %s: got data=%0d zero=%0d ovf=%0d, want data=%0d zero=%0d ovf=%0d",
                     tag, result, zero_flag, ovf_flag, exp_data, exp_zero, exp_ovf);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got running, want finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lf;
        @(negedge clk);
        step(1, 1500, 3, 3, "R7 reset");
        rst = 1'b0;
        step(0, 0, 0, 3, "R7 after reset");
        // R1 plain differences
        step(1, 500, 100, 3, "R1");
        step(1, 1919, 0, 3, "R1 just below 11-bit limit");
        step(1, 255, 254, 0, "R1 8-bit");
        // R2 equal values
        step(1, 300, 300, 3, "R2");
        // R3 borrow
        step(1, 5, 900, 3, "R3");
        step(1, 0, 2047, 2, "R3 max borrow");
        // R4 thresholds per resolution
        step(1, 256, 0, 0, "R4 8-bit at 256");
        step(1, 255, 0, 0, "R4 8-bit at 255");
        step(1, 512, 12, 0, "R4 8-bit bit9 outside mask");
        step(1, 512, 0, 1, "R4 9-bit at 512");
        step(1, 511, 1, 1, "R4 9-bit at 511");
        step(1, 1024, 0, 2, "R4 10-bit at 1024");
        step(1, 1023, 23, 2, "R4 10-bit at 1023");
        step(1, 1920, 0, 3, "R4 11-bit at 1920");
        step(1, 1792, 0, 3, "R4 11-bit partial mask");
        // R5 overflow beats the clamp
        step(1, 1920, 2000, 3, "R5");
        step(1, 300, 2047, 0, "R5 8-bit big pedestal");
        // R6 hold while idle
        step(0, 10, 900, 3, "R6");
        step(0, 2047, 0, 0, "R6 overflow input ignored");
        step(1, 700, 200, 2, "R1 reload");
        step(0, 0, 700, 2, "R6 clamp input ignored");
        // mixed patterns
        lf = 32'h1ACE;
        for (int i = 0; i < 400; i++) begin
            lf = (lf * 1103515245 + 12345) & 32'h7FFFFFFF;
            step((lf / 7) % 4 != 0, (lf / 11) % 2048, (lf / 3) % 1024, (lf / 13) % 4,
                 "R1/R2/R3/R4/R5/R6 mixed");
        end
        rst = 1'b1;
        step(1, 2047, 0, 3, "R7 late reset");
        rst = 1'b0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule